// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit forms the memory operand address for a datapath whose instructions may take one operand from memory. A request carries a three-bit mode code, a base register value, an index register value, a constant (used as a displacement or as an absolute address) and a two-bit size code. The unit returns the operand address with a one-cycle `done` pulse. For the auto-modifying modes it also returns a new base register value with a write enable.

Most modes are pure arithmetic, and their result appears on the cycle after the request is accepted. The memory-indirect mode first reads a pointer through a read port with one cycle of latency, and the pointer it reads becomes the operand address. During that sequence the unit raises `busy` and ignores any new request. The size code `s` stands for an operand of `1 << s` bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8). All address arithmetic wraps modulo 2^AW.

A three-state controller sequences the work. Its states are IDLE, FETCH and WAIT. The named transitions are:
- IDLE to IDLE (ACCEPT_DIRECT): a non-indirect request is accepted, or no request is present.
- IDLE to FETCH (ACCEPT_INDIRECT): a memory-indirect request is accepted.
- FETCH to WAIT (ISSUE_READ): the pointer read is issued.
- WAIT to IDLE (CAPTURE_PTR): the returned pointer is captured and `done` is raised.

Top module: `ea_unit`

## Requirements
- R1: After reset, `busy`, `done`, `wb_en` and `mem_rd_en` are low and `ea_addr` is zero.
- R2: Mode 0 (displacement) gives the address `req_const + req_base`.
- R3: Mode 1 (register indirect) gives the address `req_base`.
- R4: Mode 2 (indexed) gives the address `req_base + req_index`.
- R5: Mode 3 (absolute) gives the address `req_const`.
- R6: Mode 7 (scaled index) gives the address `req_const + req_base + (req_index << req_size)`.
- R7: Mode 5 (post-increment) gives the address `req_base`. It also gives `wb_value = req_base + (1 << req_size)` with `wb_en` high.
- R8: Mode 6 (pre-decrement) gives the same value `req_base - (1 << req_size)` on both `ea_addr` and `wb_value`, with `wb_en` high.
- R9: Mode 4 (memory indirect) drives `mem_rd_en` high for exactly one cycle. This happens in the cycle after acceptance, with `mem_rd_addr = req_base`. `busy` is high from that cycle until `done`. `done` comes two cycles after the read cycle, with `ea_addr` equal to the read data and `wb_en` low.
- R10: For every non-indirect mode, `done` is high in the cycle after the request is accepted. `wb_en` is high only together with `done`, and only for modes 5 and 6.
- R11: A request presented while `busy` is high is ignored. It produces no `done`, no read and no change to the result of the sequence in progress.
- R12: Address and writeback arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Mode code (0..7) |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_const | input | AW | Displacement or absolute constant |
| req_size | input | 2 | log2 of operand size in bytes |
| busy | output | 1 | Memory-indirect sequence in progress |
| done | output | 1 | Result valid pulse |
| ea_addr | output | AW | Final operand address (held until next result) |
| wb_en | output | 1 | Base writeback enable (with done) |
| wb_value | output | AW | New base register value |
| mem_rd_en | output | 1 | Pointer read request |
| mem_rd_addr | output | AW | Pointer read address |
| mem_rd_data | input | AW | Pointer read data, valid one cycle after the request |

## Verification
The bench builds the unit with AW = 16. This makes the wrap cases easy to reach with small constants: a pre-decrement from zero, and a post-increment near the top of the space. The bench covers all four size codes, so the step and index scaling are seen at every shift amount. Its memory model returns a value derived from the read address, so a wrong pointer address shows up in the final address. It also sends a request during the indirect read to show that such a request is dropped.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        MODE_DISP    = 3'd0,
        MODE_RIND    = 3'd1,
        MODE_INDEX   = 3'd2,
        MODE_ABS     = 3'd3,
        MODE_MIND    = 3'd4,
        MODE_POSTINC = 3'd5,
        MODE_PREDEC  = 3'd6,
        MODE_SCALED  = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } ea_state_e;

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  ea_mode_e        mode,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [AW-1:0]   cst,
    input  logic [1:0]      size,
    output logic [AW-1:0]   addr,
    output logic            wb_en,
    output logic [AW-1:0]   wb_val,
    output logic            needs_fetch
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] step;
    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] base_dec;

    always_comb begin
        step       = ONE << size;
        scaled_idx = index << size;
        base_dec   = base - step;
    end

    always_comb begin
        addr        = '0;
        wb_en       = 1'b0;
        wb_val      = base;
        needs_fetch = 1'b0;
        unique case (mode)
            MODE_DISP:    addr = cst + base;
            MODE_RIND:    addr = base;
            MODE_INDEX:   addr = base + index;
            MODE_ABS:     addr = cst;
            MODE_MIND: begin
                addr        = base;
                needs_fetch = 1'b1;
            end
            MODE_POSTINC: begin
                addr   = base;
                wb_en  = 1'b1;
                wb_val = base + step;
            end
            MODE_PREDEC: begin
                addr   = base_dec;
                wb_en  = 1'b1;
                wb_val = base_dec;
            end
            MODE_SCALED:  addr = cst + base + scaled_idx;
            default:      addr = '0;
        endcase
    end

endmodule

// File: rtl/ea_seq_fsm.sv
module ea_seq_fsm
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic needs_fetch,
    output logic busy,
    output logic rd_issue,
    output logic cap_direct,
    output logic cap_ptr
);

    ea_state_e state_q;
    ea_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        busy       = 1'b0;
        rd_issue   = 1'b0;
        cap_direct = 1'b0;
        cap_ptr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && needs_fetch) begin
                    state_d = ST_FETCH;
                end else if (start) begin
                    cap_direct = 1'b1;
                end
            end
            ST_FETCH: begin
                busy     = 1'b1;
                rd_issue = 1'b1;
                state_d  = ST_WAIT;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                cap_ptr = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_mode,
    input  logic [AW-1:0]   req_base,
    input  logic [AW-1:0]   req_index,
    input  logic [AW-1:0]   req_const,
    input  logic [1:0]      req_size,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   ea_addr,
    output logic            wb_en,
    output logic [AW-1:0]   wb_value,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_rd_addr,
    input  logic [AW-1:0]   mem_rd_data
);

    logic [AW-1:0] calc_addr;
    logic          calc_wb_en;
    logic [AW-1:0] calc_wb_val;
    logic          calc_fetch;
    logic          fsm_busy;
    logic          rd_issue;
    logic          cap_direct;
    logic          cap_ptr;
    logic          start;

    logic [AW-1:0] ptr_addr_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] wb_val_q;
    logic          wb_en_q;
    logic          done_q;

    ea_addr_calc #(.AW(AW)) calc_i (
        .mode        (ea_mode_e'(req_mode)),
        .base        (req_base),
        .index       (req_index),
        .cst         (req_const),
        .size        (req_size),
        .addr        (calc_addr),
        .wb_en       (calc_wb_en),
        .wb_val      (calc_wb_val),
        .needs_fetch (calc_fetch)
    );

    assign start = req_valid;

    ea_seq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .needs_fetch (calc_fetch),
        .busy        (fsm_busy),
        .rd_issue    (rd_issue),
        .cap_direct  (cap_direct),
        .cap_ptr     (cap_ptr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_addr_q <= '0;
            addr_q     <= '0;
            wb_val_q   <= '0;
            wb_en_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            wb_en_q <= 1'b0;
            if (cap_direct) begin
                addr_q   <= calc_addr;
                wb_val_q <= calc_wb_val;
                wb_en_q  <= calc_wb_en;
                done_q   <= 1'b1;
            end else if (cap_ptr) begin
                addr_q <= mem_rd_data;
                done_q <= 1'b1;
            end
            if (!fsm_busy && start && calc_fetch) begin
                ptr_addr_q <= req_base;
            end
        end
    end

    assign busy        = fsm_busy;
    assign done        = done_q;
    assign ea_addr     = addr_q;
    assign wb_en       = wb_en_q;
    assign wb_value    = wb_val_q;
    assign mem_rd_en   = rd_issue;
    assign mem_rd_addr = ptr_addr_q;

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_mode,
    input logic       busy,
    input logic       done,
    input logic       wb_en,
    input logic       mem_rd_en
);

    AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9
    AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en); // R9
    AST_FETCH_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 done); // R9
    AST_INDIRECT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode == 3'd4) |=> (mem_rd_en && busy)); // R9
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R10
    AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_mode != 3'd4) |=> done); // R10
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> !mem_rd_en); // R11

endmodule

bind ea_unit ea_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .busy      (busy),
    .done      (done),
    .wb_en     (wb_en),
    .mem_rd_en (mem_rd_en)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
    import ea_pkg::*;

    localparam int AW = 16;
    localparam logic [AW-1:0] PTR_KEY = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_mode = 3'd0;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_index = '0;
    logic [AW-1:0] req_const = '0;
    logic [1:0]    req_size = 2'd0;
    logic          busy;
    logic          done;
    logic [AW-1:0] ea_addr;
    logic          wb_en;
    logic [AW-1:0] wb_value;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [AW-1:0] mem_rd_data = '0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_addr_q[$];
    logic          exp_wbe_q[$];
    logic [AW-1:0] exp_wbv_q[$];
    string         exp_tag_q[$];

    always #2 clk = ~clk;

    ea_unit #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_base(req_base), .req_index(req_index), .req_const(req_const),
        .req_size(req_size), .busy(busy), .done(done), .ea_addr(ea_addr),
        .wb_en(wb_en), .wb_value(wb_value), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_rd_addr ^ PTR_KEY;
    end

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected result for every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_addr_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R11 unexpected done actual=%h expected=none", ea_addr);
            end else begin
                automatic string tg = exp_tag_q.pop_front();
                automatic logic ewe = exp_wbe_q.pop_front();
                automatic logic [AW-1:0] ewv = exp_wbv_q.pop_front();
                check({tg, " addr"}, ea_addr, exp_addr_q.pop_front());
                check({tg, " wb_en (R10)"}, AW'(wb_en), AW'(ewe));
                if (ewe) check({tg, " wb_value"}, wb_value, ewv);
            end
        end
    end

    function automatic logic [AW-1:0] step_of(input logic [1:0] s);
        case (s)
            2'd0: return 16'd1;
            2'd1: return 16'd2;
            2'd2: return 16'd4;
            default: return 16'd8;
        endcase
    endfunction

    task automatic push_exp(input string tag, input logic [AW-1:0] a,
                            input logic we, input logic [AW-1:0] wv);
        exp_tag_q.push_back(tag);
        exp_addr_q.push_back(a);
        exp_wbe_q.push_back(we);
        exp_wbv_q.push_back(wv);
    endtask

    // Driver: one-cycle direct request, expected item pushed before it is sent
    task automatic issue(input string tag, input logic [2:0] m, input logic [AW-1:0] b,
                         input logic [AW-1:0] x, input logic [AW-1:0] c, input logic [1:0] s);
        logic [AW-1:0] a;
        logic          we;
        logic [AW-1:0] wv;
        we = 1'b0;
        wv = b;
        case (m)
            3'd0: a = c + b;
            3'd1: a = b;
            3'd2: a = b + x;
            3'd3: a = c;
            3'd5: begin a = b; we = 1'b1; wv = b + step_of(s); end
            3'd6: begin a = b - step_of(s); we = 1'b1; wv = a; end
            default: a = c + b + x * step_of(s);
        endcase
        push_exp(tag, a, we, wv);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m; req_base = b; req_index = x;
        req_const = c; req_size = s;
    endtask

    task automatic idle_req();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Memory-indirect sequence, with a dropped request while busy (R11)
    task automatic issue_indirect(input logic [AW-1:0] b, input bit poke);
        push_exp("R9", b ^ PTR_KEY, 1'b0, '0);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 3'd4; req_base = b; req_size = 2'd2;
        @(negedge clk);
        check("R9 mem_rd_en", AW'(mem_rd_en), AW'(1));
        check("R9 mem_rd_addr", mem_rd_addr, b);
        check("R9 busy", AW'(busy), AW'(1));
        if (poke) begin
            req_mode = 3'd3; req_const = 16'h1234; req_base = 16'h0;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        check("R9 busy wait", AW'(busy), AW'(1));
        check("R11 no second read", AW'(mem_rd_en), AW'(0));
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 busy low at done", AW'(busy), AW'(0));
        @(negedge clk);
        check("R11 addr kept", ea_addr, b ^ PTR_KEY);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", AW'(busy), '0);
        check("R1 done", AW'(done), '0);
        check("R1 wb_en", AW'(wb_en), '0);
        check("R1 mem_rd_en", AW'(mem_rd_en), '0);
        check("R1 ea_addr", ea_addr, '0);
        rst_n = 1'b1;
        @(negedge clk);

        issue("R2", 3'd0, 16'h1000, 16'h0, 16'h0040, 2'd0);
        issue("R3", 3'd1, 16'hBEEF, 16'h7, 16'h0040, 2'd1);
        issue("R4", 3'd2, 16'h0200, 16'h0033, 16'h9999, 2'd2);
        issue("R5", 3'd3, 16'h0200, 16'h0033, 16'h4321, 2'd3);
        issue("R6", 3'd7, 16'h0020, 16'h0003, 16'h0100, 2'd3);
        issue("R6", 3'd7, 16'h0020, 16'h0005, 16'h0100, 2'd0);
        issue("R6", 3'd7, 16'h0001, 16'h0011, 16'h0000, 2'd1);
        issue("R7", 3'd5, 16'h0400, 16'h0, 16'h0, 2'd2);
        issue("R8", 3'd6, 16'h0400, 16'h0, 16'h0, 2'd1);
        idle_req();
        issue("R12 R8", 3'd6, 16'h0000, 16'h0, 16'h0, 2'd3);
        issue("R12 R7", 3'd5, 16'hFFFE, 16'h0, 16'h0, 2'd2);
        issue("R12 R2", 3'd0, 16'hFFF0, 16'h0, 16'h0020, 2'd0);
        issue("R12 R6", 3'd7, 16'hFF00, 16'h4000, 16'h0100, 2'd2);
        idle_req();
        @(negedge clk);

        issue_indirect(16'h0ABC, 1'b0);
        issue_indirect(16'h1357, 1'b1);
        issue("R10", 3'd1, 16'h2222, 16'h0, 16'h0, 2'd0);
        idle_req();
        repeat (4) @(negedge clk);

        vectors++;
        if (exp_addr_q.size() != 0) begin
            miscompares++;
            $display("FAIL R10 pending results actual=%0d expected=0", exp_addr_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule